// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave

This block is the slave side of a byte-addressed serial SRAM with the memory array built in. A host frames each transaction with an active-low chip select and clocks it with a serial clock. Every transaction opens with an 8-bit opcode. Reads and writes follow the opcode with a 24-bit address and then a stream of data bytes. Mode-register accesses follow it with a single data byte. All fields travel most significant bit first.

The bus can run one, two or four bits per clock. The host changes the width at run time with in-band commands, and each such command must be sent at the width that is active when it is issued. The block drives a separate output enable for each of the four shared data lines, so the pads outside can be bidirectional. In the one- and two-line widths, data line 3 acts as an active-low pause input. The mode register selects how the internal address pointer moves from one byte to the next: it stays on a single byte, wraps inside a 32-byte page, or runs through the whole array.

The block runs on a fast internal clock. It samples the serial clock, finds its edges, and acts on them.

Top module: `msram_slave`

## Requirements
- R1: After reset the bus width is one line, the mode register reads 0x40 (sequential stepping), and all four output enables are 0.
- R2: Opcode 0x02 writes and 0x03 reads. Each is followed by a 24-bit address, of which only the low ADDR_W bits select a byte. In one-line width, input is taken from line 0 and output is driven on line 1 with enable mask 4'b0010.
- R3: Data lines are sampled on a rising serial clock edge. An output line changes only while the serial clock is low, after a falling edge.
- R4: Mode bits 7:6 = 01 (sequential): the pointer increments across page boundaries and wraps from the last array byte to byte 0.
- R5: Mode bits 7:6 = 10 (page): the pointer wraps from the last byte of a 32-byte page to the first byte of the same page. Bytes outside that page are untouched.
- R6: Mode bits 7:6 = 00 (single byte): exactly one data byte is transferred. Any further clocks in the same frame have no effect on the memory.
- R7: Opcode 0x05 returns the mode register as {mode[1:0], 6'b0}. Opcode 0x01 takes one byte, and bits 7:6 of that byte become the mode.
- R8: Opcode 0x3B selects two-line width. Each clock then carries two bits, with line 1 holding the higher bit, and reads drive enable mask 4'b0011.
- R9: Opcode 0x38 selects four-line width. Each clock then carries a nibble, with line 3 as the MSB, and reads drive mask 4'b1111. Opcode 0xFF, sent at the current width (two clocks with all lines high in four-line width), returns to one-line width.
- R10: In two- and four-line widths, a read inserts one dummy byte time after the address before the first data byte.
- R11: While chip select is high, all output enables are 0 and any transaction in progress is dropped. The bus width changes only while chip select is low.
- R12: In one- and two-line widths, line 3 low (applied while the serial clock is low) pauses the transaction. All output enables drop to 0 in the same cycle, and serial clock edges are ignored until line 3 returns high with the clock low.
- R13: An unrecognised opcode makes the block ignore the rest of the frame. It drives no output and writes nothing until chip select rises.
- R14: In four-line width, line 3 is data only and never pauses the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, several times faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select framing a transaction |
| sck | input | 1 | Serial clock from the host |
| sioIn | input | 4 | Input side of the four data lines; line 3 doubles as the pause input |
| sioOut | output | 4 | Output side of the four data lines |
| sioOe | output | 4 | Per-line output enable |

## Verification
The checker watches properties that hold on every cycle. The output enables must stay quiet while chip select is high or a pause is held. The enable pattern must fit the current width. The output lines may move only after a cycle with the serial clock low. The width may change only inside a frame. The bench scenarios cover what only end-to-end data can reveal: MSB-first bit order on each width, the dummy byte, the three pointer stepping rules, address aliasing, and that an unknown opcode or a paused clock leaves memory and stream position untouched.

// File: rtl/msram_pkg.sv
`timescale 1ns/1ps
package msram_pkg;

  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2
  } lane_w_e;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_MODE_R = 8'h05;
  localparam logic [7:0] OP_MODE_W = 8'h01;
  localparam logic [7:0] OP_TO_TWO = 8'h3B;
  localparam logic [7:0] OP_TO_FOUR = 8'h38;
  localparam logic [7:0] OP_TO_ONE = 8'hFF;

  localparam logic [1:0] STEP_BYTE = 2'b00;
  localparam logic [1:0] STEP_SEQ  = 2'b01;
  localparam logic [1:0] STEP_PAGE = 2'b10;

  typedef struct packed {
    logic shiftEn;
    logic loadPtr;
    logic stepPtr;
    logic memWr;
    logic modeWr;
    logic txLoad;
    logic txFromMode;
    logic txShift;
  } dp_strobe_t;

endpackage

// File: rtl/msram_ctrl.sv
`timescale 1ns/1ps
module msram_ctrl
  import msram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       holdLine,
  input  logic [7:0] rxByte,
  input  logic [1:0] stepMode,
  output dp_strobe_t stb,
  output lane_w_e    laneW,
  output logic       driveOut
);

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA, PH_MRD, PH_MWR, PH_IDLE
  } phase_e;

  localparam int CNT_W = 5;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             sckQ;
  logic             paused;
  logic             outActive;
  logic             rdOp;

  logic             sckRise;
  logic             sckFall;
  logic             holdLow;
  logic             live;
  logic [CNT_W-1:0] lastByteCnt;
  logic [CNT_W-1:0] lastAddrCnt;
  logic             byteEnd;
  logic             addrEnd;
  logic             outPhase;
  logic             singleByte;

  assign sckRise    = sck & ~sckQ;
  assign sckFall    = ~sck & sckQ;
  assign holdLow    = (laneW != LW_FOUR) & ~holdLine;
  assign live       = ~csN & ~paused;
  assign outPhase   = (phase == PH_RDATA) | (phase == PH_MRD);
  assign singleByte = (stepMode == STEP_BYTE);

  always_comb begin
    case (laneW)
      LW_ONE:  begin lastByteCnt = 5'd7; lastAddrCnt = 5'd23; end
      LW_TWO:  begin lastByteCnt = 5'd3; lastAddrCnt = 5'd11; end
      default: begin lastByteCnt = 5'd1; lastAddrCnt = 5'd5;  end
    endcase
  end

  assign byteEnd = (cnt == lastByteCnt);
  assign addrEnd = (cnt == lastAddrCnt);

  always_comb begin
    stb = '0;
    if (live && sckRise) begin
      stb.shiftEn = 1'b1;
      case (phase)
        PH_ADDR:  stb.loadPtr = addrEnd;
        PH_RDATA: stb.stepPtr = byteEnd;
        PH_WDATA: begin
          stb.memWr   = byteEnd;
          stb.stepPtr = byteEnd;
        end
        PH_MWR:   stb.modeWr = byteEnd;
        default:  ;
      endcase
    end
    if (live && sckFall && outPhase) begin
      stb.txLoad     = (cnt == '0);
      stb.txShift    = (cnt != '0);
      stb.txFromMode = (phase == PH_MRD);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      sckQ      <= 1'b0;
      paused    <= 1'b0;
      outActive <= 1'b0;
      rdOp      <= 1'b0;
      laneW     <= LW_ONE;
    end else begin
      sckQ <= sck;
      if (csN) begin
        phase     <= PH_CMD;
        cnt       <= '0;
        paused    <= 1'b0;
        outActive <= 1'b0;
      end else begin
        if (laneW == LW_FOUR) paused <= 1'b0;
        else if (!sck)        paused <= ~holdLine;

        if (live && sckFall && outPhase) outActive <= 1'b1;

        if (live && sckRise) begin
          case (phase)
            PH_CMD: begin
              if (byteEnd) begin
                cnt <= '0;
                case (rxByte)
                  OP_READ:    begin rdOp <= 1'b1; phase <= PH_ADDR; end
                  OP_WRITE:   begin rdOp <= 1'b0; phase <= PH_ADDR; end
                  OP_MODE_R:  phase <= PH_MRD;
                  OP_MODE_W:  phase <= PH_MWR;
                  OP_TO_TWO:  begin laneW <= LW_TWO;  phase <= PH_IDLE; end
                  OP_TO_FOUR: begin laneW <= LW_FOUR; phase <= PH_IDLE; end
                  OP_TO_ONE:  begin laneW <= LW_ONE;  phase <= PH_IDLE; end
                  default:    phase <= PH_IDLE;
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_ADDR: begin
              if (addrEnd) begin
                cnt <= '0;
                if (!rdOp)               phase <= PH_WDATA;
                else if (laneW == LW_ONE) phase <= PH_RDATA;
                else                      phase <= PH_DUMMY;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DUMMY: begin
              if (byteEnd) begin
                cnt   <= '0;
                phase <= PH_RDATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_RDATA, PH_WDATA: begin
              if (byteEnd) begin
                cnt <= '0;
                if (singleByte) phase <= PH_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_MRD: begin
              if (byteEnd) cnt <= '0;
              else         cnt <= cnt + 1'b1;
            end
            PH_MWR: begin
              if (byteEnd) begin
                cnt   <= '0;
                phase <= PH_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign driveOut = ~csN & outActive & ~holdLow;

endmodule

// File: rtl/msram_dp.sv
`timescale 1ns/1ps
module msram_dp
  import msram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t stb,
  input  lane_w_e    laneW,
  input  logic [3:0] sioIn,
  output logic [7:0] rxByte,
  output logic [1:0] stepMode,
  output logic [3:0] sioOut
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int FRAME_W = 24;

  logic [7:0]         mem [DEPTH];
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] nextShift;
  logic [ADDR_W-1:0]  ptr;
  logic [1:0]         modeReg;
  logic [7:0]         txReg;
  logic [7:0]         txSrc;
  logic [3:0]         outReg;

  function automatic logic [3:0] headOf(input logic [7:0] b, input lane_w_e w);
    case (w)
      LW_ONE:  return {2'b00, b[7], 1'b0};
      LW_TWO:  return {2'b00, b[7:6]};
      default: return b[7:4];
    endcase
  endfunction

  function automatic logic [7:0] dropHead(input logic [7:0] b, input lane_w_e w);
    case (w)
      LW_ONE:  return {b[6:0], 1'b0};
      LW_TWO:  return {b[5:0], 2'b00};
      default: return {b[3:0], 4'b0000};
    endcase
  endfunction

  always_comb begin
    case (laneW)
      LW_ONE:  nextShift = {shiftReg[FRAME_W-2:0], sioIn[0]};
      LW_TWO:  nextShift = {shiftReg[FRAME_W-3:0], sioIn[1], sioIn[0]};
      default: nextShift = {shiftReg[FRAME_W-5:0], sioIn};
    endcase
  end

  assign rxByte   = nextShift[7:0];
  assign stepMode = modeReg;
  assign txSrc    = stb.txFromMode ? {modeReg, 6'b000000} : mem[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptr      <= '0;
      modeReg  <= STEP_SEQ;
      txReg    <= '0;
      outReg   <= '0;
    end else begin
      if (stb.shiftEn) shiftReg <= nextShift;
      if (stb.loadPtr) begin
        ptr <= nextShift[ADDR_W-1:0];
      end else if (stb.stepPtr) begin
        if (modeReg == STEP_PAGE)
          ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
        else
          ptr <= ptr + 1'b1;
      end
      if (stb.modeWr) modeReg <= nextShift[7:6];
      if (stb.txLoad) begin
        outReg <= headOf(txSrc, laneW);
        txReg  <= dropHead(txSrc, laneW);
      end else if (stb.txShift) begin
        outReg <= headOf(txReg, laneW);
        txReg  <= dropHead(txReg, laneW);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[ptr] <= nextShift[7:0];
  end

  assign sioOut = outReg;

endmodule

// File: rtl/msram_slave.sv
`timescale 1ns/1ps
module msram_slave
  import msram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic [3:0] sioIn,
  output logic [3:0] sioOut,
  output logic [3:0] sioOe
);

  dp_strobe_t stb;
  lane_w_e    laneW;
  logic       driveOut;
  logic [7:0] rxByte;
  logic [1:0] stepMode;
  logic [1:0] widthQ;
  logic [3:0] laneMask;

  msram_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sck      (sck),
    .holdLine (sioIn[3]),
    .rxByte   (rxByte),
    .stepMode (stepMode),
    .stb      (stb),
    .laneW    (laneW),
    .driveOut (driveOut)
  );

  msram_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .laneW    (laneW),
    .sioIn    (sioIn),
    .rxByte   (rxByte),
    .stepMode (stepMode),
    .sioOut   (sioOut)
  );

  always_comb begin
    case (laneW)
      LW_ONE:  laneMask = 4'b0010;
      LW_TWO:  laneMask = 4'b0011;
      default: laneMask = 4'b1111;
    endcase
  end

  assign widthQ = laneW;
  assign sioOe  = driveOut ? laneMask : 4'b0000;

endmodule

// File: rtl/msram_chk.sv
`timescale 1ns/1ps
module msram_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic [3:0] sioIn,
  input logic [3:0] sioOut,
  input logic [3:0] sioOe,
  input logic [1:0] widthQ
);

  a_r11_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sioOe == 4'b0000));

  a_r12_pause_tristate: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ != 2'd2 && !sioIn[3]) |-> (sioOe == 4'b0000));

  a_r2_one_line_mask: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ == 2'd0) |-> (sioOe == 4'b0000 || sioOe == 4'b0010));

  a_r8_two_line_mask: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ == 2'd1) |-> (sioOe == 4'b0000 || sioOe == 4'b0011));

  a_r9_four_line_mask: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ == 2'd2) |-> (sioOe == 4'b0000 || sioOe == 4'b1111));

  a_r3_out_moves_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sioOut) |-> !$past(sck));

  a_r11_width_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(widthQ) |-> !$past(csN));

  a_r1_width_legal: assert property (@(posedge clk) disable iff (!rstN)
    widthQ != 2'd3);

endmodule

bind msram_slave msram_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .sck    (sck),
  .sioIn  (sioIn),
  .sioOut (sioOut),
  .sioOe  (sioOe),
  .widthQ (widthQ)
);

// File: tb/msram_slave_tb_top.sv
`timescale 1ns/1ps
module msram_slave_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] sioIn = 4'hF;
  logic [3:0] sioOut;
  logic [3:0] sioOe;

  int         nChecks = 0;
  int         nFails = 0;
  logic [3:0] lastOe;
  logic [7:0] wBuf [16];
  logic [7:0] rBuf [16];

  always #10 clk = ~clk;

  msram_slave dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sck    (sck),
    .sioIn  (sioIn),
    .sioOut (sioOut),
    .sioOe  (sioOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic csStart();
    @(negedge clk);
    sck = 1'b0;
    sioIn = 4'hF;
    csN = 1'b0;
    tick(3);
  endtask

  task automatic csEnd();
    @(negedge clk);
    sck = 1'b0;
    tick(2);
    csN = 1'b1;
    sioIn = 4'hF;
    tick(3);
  endtask

  task automatic xferByte(input int w, input logic [7:0] tx, output logic [7:0] rx);
    int nChunk;
    logic [7:0] sh;
    nChunk = 8 / w;
    sh = tx;
    rx = '0;
    for (int k = 0; k < nChunk; k++) begin
      @(negedge clk);
      sck = 1'b0;
      case (w)
        1:       sioIn = {3'b111, sh[7]};
        2:       sioIn = {2'b11, sh[7:6]};
        default: sioIn = sh[7:4];
      endcase
      sh = sh << w;
      tick(3);
      case (w)
        1:       rx = {rx[6:0], sioOut[1]};
        2:       rx = {rx[5:0], sioOut[1:0]};
        default: rx = {rx[3:0], sioOut};
      endcase
      lastOe = sioOe;
      @(negedge clk);
      sck = 1'b1;
      tick(3);
    end
  endtask

  task automatic sendByte(input int w, input logic [7:0] b);
    logic [7:0] junk;
    xferByte(w, b, junk);
  endtask

  task automatic sendAddr(input int w, input logic [23:0] a);
    sendByte(w, a[23:16]);
    sendByte(w, a[15:8]);
    sendByte(w, a[7:0]);
  endtask

  task automatic memWrite(input int w, input logic [23:0] a, input int n);
    csStart();
    sendByte(w, 8'h02);
    sendAddr(w, a);
    for (int i = 0; i < n; i++) sendByte(w, wBuf[i]);
    csEnd();
  endtask

  task automatic memRead(input int w, input logic [23:0] a, input int n);
    logic [7:0] d;
    csStart();
    sendByte(w, 8'h03);
    sendAddr(w, a);
    if (w != 1) xferByte(w, 8'h00, d);
    for (int i = 0; i < n; i++) begin
      xferByte(w, 8'h00, d);
      rBuf[i] = d;
    end
    csEnd();
  endtask

  task automatic setMode(input int w, input logic [7:0] m);
    csStart();
    sendByte(w, 8'h01);
    sendByte(w, m);
    csEnd();
  endtask

  task automatic readMode(input int w, output logic [7:0] m);
    csStart();
    sendByte(w, 8'h05);
    xferByte(w, 8'h00, m);
    csEnd();
  endtask

  task automatic widthCmd(input int w, input logic [7:0] op);
    csStart();
    sendByte(w, op);
    csEnd();
  endtask

  task automatic testReset();
    logic [7:0] m;
    check4("R1 enables idle after reset", sioOe, 4'b0000);
    readMode(1, m);
    check8("R1 R7 mode after reset", m, 8'h40);
  endtask

  task automatic testSingleRw();
    wBuf[0] = 8'h3C; wBuf[1] = 8'h81; wBuf[2] = 8'h7E; wBuf[3] = 8'h05;
    memWrite(1, 24'h000100, 4);
    memRead(1, 24'h000100, 4);
    for (int i = 0; i < 4; i++) check8("R2 R3 one-line readback", rBuf[i], wBuf[i]);
    check4("R2 one-line enable mask", lastOe, 4'b0010);
    memRead(1, 24'hFFFD00, 1);
    check8("R2 upper address bits ignored", rBuf[0], 8'h3C);
  endtask

  task automatic testSeqWrap();
    wBuf[0] = 8'hA1; wBuf[1] = 8'hA2; wBuf[2] = 8'hA3; wBuf[3] = 8'hA4;
    memWrite(1, 24'h0003FE, 4);
    memRead(1, 24'h000000, 2);
    check8("R4 wrap to zero byte0", rBuf[0], 8'hA3);
    check8("R4 wrap to zero byte1", rBuf[1], 8'hA4);
    memRead(1, 24'h0003FF, 2);
    check8("R4 read across array end", rBuf[1], 8'hA3);
  endtask

  task automatic testPage();
    logic [7:0] m;
    wBuf[0] = 8'hEE;
    memWrite(1, 24'h000020, 1);
    setMode(1, 8'h80);
    readMode(1, m);
    check8("R7 page mode readback", m, 8'h80);
    wBuf[0] = 8'hB1; wBuf[1] = 8'hB2; wBuf[2] = 8'hB3; wBuf[3] = 8'hB4;
    memWrite(1, 24'h00001E, 4);
    memRead(1, 24'h00001F, 3);
    check8("R5 page read last", rBuf[0], 8'hB2);
    check8("R5 page read wrapped", rBuf[1], 8'hB3);
    check8("R5 page read wrapped+1", rBuf[2], 8'hB4);
    setMode(1, 8'h40);
    memRead(1, 24'h000020, 1);
    check8("R5 next page untouched", rBuf[0], 8'hEE);
  endtask

  task automatic testByteMode();
    wBuf[0] = 8'h10; wBuf[1] = 8'h20;
    memWrite(1, 24'h000050, 2);
    setMode(1, 8'h00);
    wBuf[0] = 8'h77; wBuf[1] = 8'h88;
    memWrite(1, 24'h000050, 2);
    setMode(1, 8'h40);
    memRead(1, 24'h000050, 2);
    check8("R6 first byte written", rBuf[0], 8'h77);
    check8("R6 second byte ignored", rBuf[1], 8'h20);
  endtask

  task automatic testModeBits();
    logic [7:0] m;
    setMode(1, 8'hFF);
    readMode(1, m);
    check8("R7 low mode bits read zero", m, 8'hC0);
    setMode(1, 8'h40);
    readMode(1, m);
    check8("R7 mode restored", m, 8'h40);
  endtask

  task automatic testDualQuad();
    logic [7:0] m;
    widthCmd(1, 8'h3B);
    wBuf[0] = 8'h96; wBuf[1] = 8'h4B; wBuf[2] = 8'hD2;
    memWrite(2, 24'h000120, 3);
    memRead(2, 24'h000120, 3);
    for (int i = 0; i < 3; i++) check8("R8 R10 two-line readback", rBuf[i], wBuf[i]);
    check4("R8 two-line enable mask", lastOe, 4'b0011);
    widthCmd(2, 8'h38);
    wBuf[0] = 8'h21; wBuf[1] = 8'h07; wBuf[2] = 8'h5F;
    memWrite(4, 24'h000140, 3);
    memRead(4, 24'h000140, 3);
    for (int i = 0; i < 3; i++) check8("R9 R10 R14 four-line readback", rBuf[i], wBuf[i]);
    check4("R9 four-line enable mask", lastOe, 4'b1111);
    widthCmd(4, 8'hFF);
    readMode(1, m);
    check8("R9 back to one line", m, 8'h40);
    memRead(1, 24'h000120, 1);
    check8("R8 two-line write seen on one line", rBuf[0], 8'h96);
  endtask

  task automatic testCsAbort();
    logic [7:0] d;
    csStart();
    sendByte(1, 8'h02);
    sendByte(1, 8'h00);
    sendByte(1, 8'h01);
    csEnd();
    csStart();
    sendByte(1, 8'h03);
    sendAddr(1, 24'h000100);
    xferByte(1, 8'h00, d);
    check8("R11 fresh frame after abort", d, 8'h3C);
    check4("R11 enable while selected", sioOe, 4'b0010);
    csEnd();
    check4("R11 enable after deselect", sioOe, 4'b0000);
  endtask

  task automatic testHold();
    logic [7:0] d;
    wBuf[0] = 8'h5A; wBuf[1] = 8'hC3;
    memWrite(1, 24'h000200, 2);
    csStart();
    sendByte(1, 8'h03);
    sendAddr(1, 24'h000200);
    xferByte(1, 8'h00, d);
    check8("R12 byte before pause", d, 8'h5A);
    @(negedge clk);
    sck = 1'b0;
    tick(3);
    sioIn[3] = 1'b0;
    #1;
    check4("R12 tristate at once", sioOe, 4'b0000);
    tick(3);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sck = ~sck;
      sioIn[0] = ~sioIn[0];
      tick(2);
    end
    check4("R12 tristate while paused", sioOe, 4'b0000);
    sioIn[3] = 1'b1;
    tick(3);
    check4("R12 enable after resume", sioOe, 4'b0010);
    xferByte(1, 8'h00, d);
    check8("R12 stream position kept", d, 8'hC3);
    csEnd();
  endtask

  task automatic testBadOpcode();
    csStart();
    sendByte(1, 8'h77);
    sendByte(1, 8'h02);
    sendAddr(1, 24'h000200);
    sendByte(1, 8'h11);
    check4("R13 no drive after bad opcode", sioOe, 4'b0000);
    csEnd();
    memRead(1, 24'h000200, 1);
    check8("R13 memory untouched", rBuf[0], 8'h5A);
  endtask

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(4);
    testReset();
    testSingleRw();
    testSeqWrap();
    testPage();
    testByteMode();
    testModeBits();
    testDualQuad();
    testCsAbort();
    testHold();
    testBadOpcode();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule